// File: doc/BRIEF.md
# Gated Dual General-Purpose Timer

This block holds two independent 16-bit up-counters that share one configuration register. Each counter has an active-low gate input: it advances only while its gate is low and holds while the gate is high. A per-timer gate mode selects one of two behaviours. In restart mode, every falling edge of the gate zeroes the count before counting resumes. In plain mode, the gate only enables counting.

Each timer also has an enable bit and a stop bit. When the enable bit is clear, the timer and all of its registers are held cleared. When the stop bit is set, the counting logic freezes, but the register port keeps working. A reference compare raises a sticky event flag and can optionally zero the count. A rising edge on a per-timer capture input copies the live count into a capture register and raises a sticky event flag.

Each timer is controlled by a three-state machine, with next state taken from the configuration:
- ST_RESET is entered from any state when the enable bit is 0.
- ST_STOP is entered from any state when the enable bit is 1 and the stop bit is 1.
- ST_RUN is entered from any state when the enable bit is 1 and the stop bit is 0.

The state register follows the configuration one clock later. The gate and capture inputs pass through a two-flop synchronizer. Edges are detected on the synchronized signal.

Top module: `gated_timer_pair`

## Requirements
- R1: After hardware reset, the configuration register (address 0x0) reads 0. Both timers are then in ST_RESET with restart gate mode selected. Every timer register reads 0.
- R2: In ST_RUN, the count increases by one per clock for each clock in which the synchronized gate is low. The count holds while the gate is high. In plain mode, a gate held low for N clocks adds exactly N.
- R3: In restart gate mode (configuration bit 4t+2 = 0), a synchronized falling edge of the gate sets the count to 0 in that cycle; the restart takes precedence over the increment. A gate held low for N clocks leaves the count at N-1.
- R4: In plain gate mode (configuration bit 4t+2 = 1), a falling edge of the gate does not alter the count. Counting continues from the held value.
- R5: While the enable bit (configuration bit 4t) is 0, the timer's mode, reference, count, capture and event registers are cleared. Writes to them have no effect.
- R6: While the enable bit is 1 and the stop bit (configuration bit 4t+1) is 1, the count and capture are frozen. Register writes still take effect. Counting resumes from the frozen value only after the stop bit is cleared.
- R7: A counting step taken while the count equals the reference sets event bit 0. The bit stays set until software writes 1 to bit 0 of the event register. If a set and a clear fall in the same cycle, the set wins.
- R8: With mode register bit 0 = 1, a counting step taken while the count equals the reference produces 0 instead of reference+1.
- R9: In ST_RUN, a synchronized rising edge of the capture input copies the count held before that clock edge into the capture register and sets event bit 1. Writing 1 to event bit 1 clears it.
- R10: The count wraps from 0xFFFF to 0x0000.
- R11: The two timers are independent. Gate, capture and configuration activity of one timer does not change the other.
- R12: Register map:
  - Address 0x0 is the configuration register, with 4 bits per timer t at bits 4t..4t+3; bit 4t+3 reads 0.
  - Timer t registers sit at 8t + k: k=1 mode, k=2 reference, k=3 count (read-only), k=4 capture (read-only), k=5 event (bit 0 reference, bit 1 capture).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and both timers |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| gate_n | input | 2 | Active-low gate, one bit per timer |
| cap_in | input | 2 | Capture request, rising-edge sensitive, one bit per timer |

## Verification
Two functions can fall in the same cycle:
- **Gate-restart versus capture.** The bench drives a gate falling edge and a capture rising edge on the same clock while timer 0 is in restart mode. Both inputs pass through identical synchronizers, so the restart and the capture act at the same clock edge. The capture register must then hold the pre-restart count. The count must end at N-1 for N low clocks, which shows that the restart beat the increment.
- **Reference match versus restart-on-reference.** In a second case, the count steps through the reference with restart-on-reference enabled. The bench checks that the step through the reference produces 0 and sets the reference event in the same cycle.

// File: rtl/gtp_pkg.sv
package gtp_pkg;

    localparam int GTP_CNT_W = 16;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_STOP  = 2'd1,
        ST_RUN   = 2'd2
    } tmr_state_e;

    // offsets inside one timer window of the register map
    localparam logic [2:0] OFS_MODE = 3'd1;
    localparam logic [2:0] OFS_REF  = 3'd2;
    localparam logic [2:0] OFS_CNT  = 3'd3;
    localparam logic [2:0] OFS_CAP  = 3'd4;
    localparam logic [2:0] OFS_EVT  = 3'd5;

endpackage

// File: rtl/gtp_sync.sv
module gtp_sync #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic lvl_d
);
    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {3{IDLE}};
        else        sh <= {sh[1:0], din};
    end

    assign lvl   = sh[1];
    assign lvl_d = sh[2];
endmodule

// File: rtl/gtp_timer.sv
module gtp_timer
    import gtp_pkg::*;
#(
    parameter int CNT_W = GTP_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_stop,
    input  logic             cfg_gmode,
    input  logic             gate_n,
    input  logic             cap_in,
    input  logic             wr_mode,
    input  logic             wr_ref,
    input  logic             wr_evt,
    input  logic [CNT_W-1:0] wdata,
    output logic             mode_q,
    output logic [CNT_W-1:0] ref_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cap_q,
    output logic [1:0]       evt_q
);
    tmr_state_e state, state_nx;
    logic hold_clr, active;
    logic gate_lvl, gate_lvl_d, cap_lvl, cap_lvl_d;
    logic gate_fall, cap_rise, restart, step, ref_hit, cap_hit;

    gtp_sync #(.IDLE(1'b1)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .din(gate_n), .lvl(gate_lvl), .lvl_d(gate_lvl_d));
    gtp_sync #(.IDLE(1'b0)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .lvl(cap_lvl), .lvl_d(cap_lvl_d));

    assign gate_fall = gate_lvl_d & ~gate_lvl;
    assign cap_rise  = cap_lvl & ~cap_lvl_d;

    // next-state selection from configuration
    always_comb begin
        if (!cfg_en)      state_nx = ST_RESET;
        else if (cfg_stop) state_nx = ST_STOP;
        else               state_nx = ST_RUN;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= state_nx;
    end

    // state outputs
    always_comb begin
        hold_clr = 1'b0;
        active   = 1'b0;
        unique case (state)
            ST_RESET: hold_clr = 1'b1;
            ST_STOP:  active   = 1'b0;
            ST_RUN:   active   = 1'b1;
            default:  hold_clr = 1'b1;
        endcase
    end

    assign restart = active & ~cfg_gmode & gate_fall;
    assign step    = active & ~gate_lvl & ~restart;
    assign ref_hit = step & (cnt_q == ref_q);
    assign cap_hit = active & cap_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_clr || restart) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (ref_hit && mode_q) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            ref_q  <= '0;
            cap_q  <= '0;
            evt_q  <= '0;
        end else if (hold_clr) begin
            mode_q <= 1'b0;
            ref_q  <= '0;
            cap_q  <= '0;
            evt_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= wdata[0];
            if (wr_ref)  ref_q  <= wdata;
            if (cap_hit) cap_q  <= cnt_q;
            evt_q <= (evt_q & ~(wr_evt ? wdata[1:0] : 2'b00)) | {cap_hit, ref_hit};
        end
    end

    // ---------------- assertions ----------------
    assert_hold_gate_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && gate_lvl) |=> $stable(cnt_q));

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !cfg_gmode && gate_fall) |=> (cnt_q == '0));

    assert_plain_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cfg_gmode && gate_fall && !(mode_q && cnt_q == ref_q))
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET) |=> (cnt_q == '0 && ref_q == '0 && cap_q == '0
                                 && evt_q == 2'b00 && !mode_q));

    assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |=> ($stable(cnt_q) && $stable(cap_q)));

    assert_ref_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !gate_lvl && !gate_fall && cnt_q == ref_q) |=> evt_q[0]);

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cap_rise) |=> (cap_q == $past(cnt_q) && evt_q[1]));

    assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == {CNT_W{1'b1}} && !(mode_q && ref_q == cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/gated_timer_pair.sv
module gated_timer_pair
    import gtp_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int CNT_W   = GTP_CNT_W,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic [NUM_TMR-1:0] gate_n,
    input  logic [NUM_TMR-1:0] cap_in
);
    localparam int TSEL_W = ADDR_W - 3;
    localparam int CFG_W  = 4 * NUM_TMR;

    function automatic logic [CFG_W-1:0] make_cfg_mask();
        logic [CFG_W-1:0] m;
        m = '0;
        for (int t = 0; t < NUM_TMR; t++) m[4*t +: 3] = 3'b111;
        return m;
    endfunction

    localparam logic [CFG_W-1:0] CFG_MASK = make_cfg_mask();

    logic [CFG_W-1:0]  cfg_q;
    logic [TSEL_W-1:0] sel_t;
    logic [2:0]        ofs;
    logic [NUM_TMR-1:0] mode_a;
    logic [CNT_W-1:0]  ref_a [NUM_TMR];
    logic [CNT_W-1:0]  cnt_a [NUM_TMR];
    logic [CNT_W-1:0]  cap_a [NUM_TMR];
    logic [1:0]        evt_a [NUM_TMR];

    assign sel_t = reg_addr[ADDR_W-1:3];
    assign ofs   = reg_addr[2:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (reg_we && reg_addr == '0)
            cfg_q <= reg_wdata[CFG_W-1:0] & CFG_MASK;
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic hit;
        assign hit = reg_we && (sel_t == TSEL_W'(t));
        gtp_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_en   (cfg_q[4*t]),
            .cfg_stop (cfg_q[4*t+1]),
            .cfg_gmode(cfg_q[4*t+2]),
            .gate_n   (gate_n[t]),
            .cap_in   (cap_in[t]),
            .wr_mode  (hit && ofs == OFS_MODE),
            .wr_ref   (hit && ofs == OFS_REF),
            .wr_evt   (hit && ofs == OFS_EVT),
            .wdata    (reg_wdata),
            .mode_q   (mode_a[t]),
            .ref_q    (ref_a[t]),
            .cnt_q    (cnt_a[t]),
            .cap_q    (cap_a[t]),
            .evt_q    (evt_a[t])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata = CNT_W'(cfg_q);
        end else begin
            for (int t = 0; t < NUM_TMR; t++) begin
                if (sel_t == TSEL_W'(t)) begin
                    case (ofs)
                        OFS_MODE: reg_rdata = CNT_W'(mode_a[t]);
                        OFS_REF:  reg_rdata = ref_a[t];
                        OFS_CNT:  reg_rdata = cnt_a[t];
                        OFS_CAP:  reg_rdata = cap_a[t];
                        OFS_EVT:  reg_rdata = CNT_W'(evt_a[t]);
                        default:  reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    assert_cfg_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0 || !rst_n));
endmodule

// File: tb/gated_timer_pair_tb.sv
module gated_timer_pair_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [1:0]  gate_n = 2'b11;
    logic [1:0]  cap_in = 2'b00;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    logic [3:0]  adr_q[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    gated_timer_pair dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gate_n(gate_n), .cap_in(cap_in));

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // driver: selects the register and queues the expected value
    task automatic expect_rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        adr_q.push_back(a); exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk);
        #(CLK_P/4 + 1);
    endtask

    // hold selected gates low (and capture inputs high) for n clocks
    task automatic pulse(input logic [1:0] gmask, input int n, input logic [1:0] cmask);
        @(negedge clk);
        gate_n = ~gmask; cap_in = cmask;
        repeat (n) @(negedge clk);
        gate_n = 2'b11; cap_in = 2'b00;
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                logic [3:0] a; logic [15:0] e; string tg;
                a = adr_q.pop_front(); e = exp_q.pop_front(); tg = tag_q.pop_front();
                n_chk++;
                if (reg_rdata !== e) begin
                    n_err++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", tg, a, reg_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(4'h0, 16'h0000, "R1 config after reset");
        expect_rd(4'h3, 16'h0000, "R1 t0 count after reset");
        expect_rd(4'hA, 16'h0000, "R1 t1 reference after reset");
        // R5 write ignored while disabled
        wr(4'h2, 16'h0055);
        expect_rd(4'h2, 16'h0000, "R5 reference write ignored in reset");
        // enable t0, plain mode; R12 reserved bit masked
        wr(4'h0, 16'h000D);
        expect_rd(4'h0, 16'h0005, "R12 config reserved bit reads 0");
        pulse(2'b11, 10, 2'b00);
        expect_rd(4'h3, 16'd10, "R2 plain mode count after 10 low clocks");
        expect_rd(4'hB, 16'd0, "R11 t1 unaffected while disabled");
        pulse(2'b01, 5, 2'b00);
        expect_rd(4'h3, 16'd15, "R4 plain mode falling edge keeps count");
        // restart mode
        wr(4'h0, 16'h0001);
        pulse(2'b01, 7, 2'b00);
        expect_rd(4'h3, 16'd6, "R3 restart mode count after 7 low clocks");
        // stop, plain mode
        wr(4'h0, 16'h0007);
        pulse(2'b01, 8, 2'b00);
        expect_rd(4'h3, 16'd6, "R6 count frozen while stopped");
        wr(4'h2, 16'd20);
        expect_rd(4'h2, 16'd20, "R6 register write works while stopped");
        wr(4'h0, 16'h0005);
        pulse(2'b01, 4, 2'b00);
        expect_rd(4'h3, 16'd10, "R6 counting resumes after stop cleared");
        // reference event
        wr(4'h5, 16'h0003);
        expect_rd(4'h5, 16'h0000, "R7 event cleared by writing 1");
        pulse(2'b01, 11, 2'b00);
        expect_rd(4'h3, 16'd21, "R7 count passes the reference");
        expect_rd(4'h5, 16'h0001, "R7 reference event set");
        wr(4'h5, 16'h0001);
        expect_rd(4'h5, 16'h0000, "R7 reference event cleared");
        // restart on reference
        wr(4'h1, 16'h0001);
        wr(4'h2, 16'd25);
        pulse(2'b01, 10, 2'b00);
        expect_rd(4'h3, 16'd5, "R8 count zeroed on reference step");
        expect_rd(4'h5, 16'h0001, "R8 reference event on restart step");
        // capture
        wr(4'h5, 16'h0003);
        pulse(2'b00, 2, 2'b01);
        expect_rd(4'h4, 16'd5, "R9 capture holds count");
        expect_rd(4'h5, 16'h0002, "R9 capture event set");
        // same-cycle restart and capture
        wr(4'h0, 16'h0001);
        wr(4'h5, 16'h0003);
        wr(4'h1, 16'h0000);
        pulse(2'b01, 3, 2'b01);
        expect_rd(4'h4, 16'd5, "R9 capture sees pre-restart count");
        expect_rd(4'h3, 16'd2, "R3 restart beats increment with capture");
        // disable clears
        wr(4'h0, 16'h0000);
        expect_rd(4'h3, 16'd0, "R5 count cleared on disable");
        expect_rd(4'h2, 16'd0, "R5 reference cleared on disable");
        expect_rd(4'h4, 16'd0, "R5 capture cleared on disable");
        expect_rd(4'h5, 16'd0, "R5 event cleared on disable");
        // t1 alone
        wr(4'h0, 16'h0050);
        pulse(2'b10, 3, 2'b00);
        expect_rd(4'hB, 16'd3, "R11 t1 counts its own gate");
        expect_rd(4'h3, 16'd0, "R11 t0 untouched by t1 gate");
        pulse(2'b10, 65533, 2'b00);
        expect_rd(4'hB, 16'd0, "R10 count wraps to zero");
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule